// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier with Carry-Save Reduction

This block multiplies two signed two's-complement operands of `W` bits (24 by default) and returns the full `2W`-bit product. The multiplier operand `b` is split into overlapping three-bit windows, with a zero placed below its lowest bit. Each window becomes one signed digit in the range -2 to +2. Every digit selects zero, the multiplicand, or twice the multiplicand from `a`, and all of these partial products are formed at the same time.

A negative digit is formed by inverting the selected multiple and adding a one at that partial product's lowest weight. All of these added ones are gathered into one extra row. The partial products and that extra row are reduced by a tree of 3:2 carry-save stages down to one sum vector and one carry vector. A grouped carry-lookahead adder then adds those two vectors to give the product.

Both operands are registered on the way in and the product is registered on the way out. Every product therefore appears two clock cycles after its operands are presented.

Top module: `booth_wallace_mul`

## Requirements
- R1: `p` equals the signed product of the `a` and `b` values sampled two rising clock edges earlier, as a `2W`-bit two's-complement value.
- R2: While `rst` is high at a rising edge, the operand and product registers clear. `p` reads 0 after that edge and stays 0 until a product of operands captured after reset arrives.
- R3: The most negative operand times itself gives +2^(2W-2) exactly. The most negative operand times the most positive one is exact as well.
- R4: A zero in either operand gives a zero product, whatever the other operand is.
- R5: All-ones (-1) in one operand gives the two's-complement negation of the other operand. This includes -1 times -1 = 1.
- R6: The carry-save tree ends in a sum vector and a carry vector. Added modulo 2^(2W), these two vectors equal the signed product of the registered operands.
- R7: The carry-lookahead adder output equals the modulo 2^(2W) sum of the two tree vectors.
- R8: Each digit is decoded from the window (bit 2i+1, bit 2i, bit 2i-1), where bit -1 is 0. The windows 000 and 111 give 0. The windows 001 and 010 give +1, and 011 gives +2. The window 100 gives -2, and the windows 101 and 110 give -1. No digit selects both magnitudes at once, and a zero digit is never negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W | Multiplicand, signed two's complement |
| b | input | W | Multiplier, signed two's complement, Booth-recoded |
| p | output | 2W | Registered signed product |

## Verification
Several checks run on every cycle. The end-to-end product is compared against a signed multiply of the operands from two edges earlier. The carry-save tree's two vectors are checked to add up to the product of the registered operands. The final adder is checked to match the plain sum of those vectors, and each decoded digit is checked to be well-formed. Some behaviour only the bench scenarios can show: the exact handling of the most negative operand, the -1 and zero operand cases, Booth patterns that drive every window code, and a reset dropped in the middle of a stream flushing the pipeline.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Rows left after one layer of 3:2 compression.
  function automatic int csa_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Rows present at a given layer of the tree.
  function automatic int csa_rows_at(input int n, input int lv);
    int r;
    r = n;
    for (int k = 0; k < lv; k++) r = csa_next(r);
    return r;
  endfunction

  // Layers needed to reach two rows.
  function automatic int csa_depth(input int n);
    int r;
    int d;
    r = n;
    d = 0;
    while (r > 2) begin
      r = csa_next(r);
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int W = 24,
  localparam int PW = 2 * W,
  localparam int ND = W / 2,
  localparam int NR = ND + 1
) (
  input  logic [W-1:0]          mcand,
  input  logic [W-1:0]          mplier,
  output logic [NR-1:0][PW-1:0] rows,
  output logic [ND-1:0]         sel1,
  output logic [ND-1:0]         sel2,
  output logic [ND-1:0]         neg
);

  logic [PW-1:0] corr;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [2:0] trip;
    logic [W:0] mult;
    logic [W:0] inv;

    if (i == 0) begin : g_lo
      assign trip = {mplier[1], mplier[0], 1'b0};
    end else begin : g_hi
      assign trip = {mplier[2*i+1], mplier[2*i], mplier[2*i-1]};
    end

    // digit magnitude and sign
    assign sel1[i] = trip[1] ^ trip[0];
    assign sel2[i] = (trip == 3'b011) || (trip == 3'b100);
    assign neg[i]  = trip[2] & ~(trip[1] & trip[0]);

    assign mult = sel2[i] ? {mcand, 1'b0}
                : (sel1[i] ? {mcand[W-1], mcand} : '0);
    assign inv  = mult ^ {(W+1){neg[i]}};

    // full sign extension keeps every row exact modulo 2^PW
    assign rows[i] = {{(PW-W-1){inv[W]}}, inv} << (2 * i);
  end

  // the +1 of every negated row, gathered into one extra row
  always_comb begin
    corr = '0;
    for (int i = 0; i < ND; i++) corr[2*i] = neg[i];
  end

  assign rows[ND] = corr;

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import mul_pkg::*;
#(
  parameter int PW = 48,
  parameter int N  = 13,
  localparam int LV = csa_depth(N)
) (
  input  logic [N-1:0][PW-1:0] ops,
  output logic [PW-1:0]        sum_v,
  output logic [PW-1:0]        car_v
);

  logic [PW-1:0] stage [LV+1][N];

  for (genvar r = 0; r < N; r++) begin : g_in
    assign stage[0][r] = ops[r];
  end

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int NIN  = csa_rows_at(N, lv);
    localparam int NGRP = NIN / 3;
    localparam int NOUT = csa_next(NIN);

    for (genvar g = 0; g < NGRP; g++) begin : g_csa
      logic [PW-1:0] x, y, z;
      assign x = stage[lv][3*g];
      assign y = stage[lv][3*g+1];
      assign z = stage[lv][3*g+2];
      assign stage[lv+1][2*g]   = x ^ y ^ z;
      assign stage[lv+1][2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
    end

    for (genvar r = 2 * NGRP; r < N; r++) begin : g_rest
      if (r < NOUT) begin : g_pass
        assign stage[lv+1][r] = stage[lv][r + NGRP];
      end else begin : g_zero
        assign stage[lv+1][r] = '0;
      end
    end
  end

  assign sum_v = stage[LV][0];
  assign car_v = stage[LV][1];

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int PW = 48,
  parameter int GW = 4,
  localparam int NG = PW / GW
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);

  logic [PW-1:0] gen, prp, cin;
  logic [NG-1:0] ggen, gprp;
  logic [NG:0]   gcar;

  assign gen = x & y;
  assign prp = x ^ y;

  // group generate / propagate
  always_comb begin : p_group
    logic acc;
    logic all;
    for (int k = 0; k < NG; k++) begin
      acc = 1'b0;
      all = 1'b1;
      for (int j = 0; j < GW; j++) begin
        acc = gen[k*GW+j] | (prp[k*GW+j] & acc);
        all = all & prp[k*GW+j];
      end
      ggen[k] = acc;
      gprp[k] = all;
    end
  end

  // flat lookahead across groups: each group carry is a sum of products
  always_comb begin : p_look
    logic term;
    logic orv;
    gcar[0] = 1'b0;
    for (int k = 0; k < NG; k++) begin
      orv = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = ggen[j];
        for (int m = j + 1; m <= k; m++) term = term & gprp[m];
        orv = orv | term;
      end
      gcar[k+1] = orv;
    end
  end

  // carries inside each group start from the lookahead carry
  always_comb begin : p_bits
    logic cr;
    for (int k = 0; k < NG; k++) begin
      cr = gcar[k];
      for (int j = 0; j < GW; j++) begin
        cin[k*GW+j] = cr;
        cr = gen[k*GW+j] | (prp[k*GW+j] & cr);
      end
    end
  end

  assign s = prp ^ cin;

endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul #(
  parameter int W  = 24,
  parameter int GW = 4,
  localparam int PW = 2 * W,
  localparam int ND = W / 2,
  localparam int NR = ND + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] p
);

  logic [W-1:0]          a_q, b_q;
  logic [NR-1:0][PW-1:0] pp_rows;
  logic [ND-1:0]         sel1, sel2, neg;
  logic [PW-1:0]         tree_s, tree_c, sum_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  booth_pp_gen #(.W(W)) i_pp (
    .mcand (a_q),
    .mplier(b_q),
    .rows  (pp_rows),
    .sel1  (sel1),
    .sel2  (sel2),
    .neg   (neg)
  );

  csa_tree #(.PW(PW), .N(NR)) i_tree (
    .ops  (pp_rows),
    .sum_v(tree_s),
    .car_v(tree_c)
  );

  cla_adder #(.PW(PW), .GW(GW)) i_cla (
    .x(tree_s),
    .y(tree_c),
    .s(sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= sum_w;
  end

endmodule

// File: rtl/booth_wallace_mul_chk.sv
module booth_wallace_mul_chk #(
  parameter int W = 24,
  localparam int PW = 2 * W,
  localparam int ND = W / 2
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic [PW-1:0] p,
  input logic [W-1:0]  a_q,
  input logic [W-1:0]  b_q,
  input logic [PW-1:0] tree_s,
  input logic [PW-1:0] tree_c,
  input logic [PW-1:0] sum_w,
  input logic [ND-1:0] sel1,
  input logic [ND-1:0] sel2,
  input logic [ND-1:0] neg
);

  function automatic logic [PW-1:0] smul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [PW-1:0] xs, ys;
    xs = {{W{x[W-1]}}, x};
    ys = {{W{y[W-1]}}, y};
    return xs * ys;
  endfunction

  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)            cyc <= 2'd0;
    else if (cyc != 3)  cyc <= cyc + 2'd1;
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2) |-> (p == smul($past(a, 2), $past(b, 2))));

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (p == '0));

  assert_tree_sum_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1) |-> ((tree_s + tree_c) == smul(a_q, b_q)));

  assert_cla_sum_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1) |-> (sum_w == tree_s + tree_c));

  assert_digit_form_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1) |-> (((sel1 & sel2) == '0) && ((neg & ~(sel1 | sel2)) == '0)));

endmodule

bind booth_wallace_mul booth_wallace_mul_chk #(.W(W)) i_chk (
  .clk   (clk),
  .rst   (rst),
  .a     (a),
  .b     (b),
  .p     (p),
  .a_q   (a_q),
  .b_q   (b_q),
  .tree_s(tree_s),
  .tree_c(tree_c),
  .sum_w (sum_w),
  .sel1  (sel1),
  .sel2  (sel2),
  .neg   (neg)
);

// File: tb/test_booth_wallace_mul.sv
module test_booth_wallace_mul;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 24;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic [PW-1:0] p;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state: two stages of expected product plus tags
  logic [PW-1:0] m1, m2;
  string tag_in = "R2";
  string t1 = "R2";
  string t2 = "R2";

  booth_wallace_mul #(.W(W)) i_booth_wallace_mul (
    .clk(clk), .rst(rst), .a(a), .b(b), .p(p)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    longint sx, sy, pr;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    pr = sx * sy;
    return pr[PW-1:0];
  endfunction

  always @(posedge clk) begin
    m1 <= rst ? '0 : ref_mul(a, b);
    m2 <= rst ? '0 : m1;
    t1 <= tag_in;
    t2 <= t1;
  end

  // compare at the falling edge, then present the next operands
  task automatic step(input logic [W-1:0] na, input logic [W-1:0] nb, input logic nr, input string tg);
    @(negedge clk);
    checks++;
    if (p !== m2) begin
      fails++;
      $display("FAIL %s: p=%h expected %h", t2, p, m2);
    end
    a = na;
    b = nb;
    rst = nr;
    tag_in = tg;
  endtask

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONES = '1;

  initial begin
    // R2: reset state with junk on the operands
    for (int i = 0; i < 3; i++) step(W'($urandom), W'($urandom), 1'b1, "R2");
    // R4: zero operands
    step('0, W'($urandom), 1'b0, "R4");
    step(W'($urandom), '0, 1'b0, "R4");
    step('0, MINV, 1'b0, "R4");
    step(MINV, '0, 1'b0, "R4");
    // R5: minus one
    step(ONES, 24'h123456, 1'b0, "R5");
    step(24'h7ABCDE, ONES, 1'b0, "R5");
    step(ONES, ONES, 1'b0, "R5");
    step(ONES, MINV, 1'b0, "R5");
    step(MINV, ONES, 1'b0, "R5");
    // R3: extreme magnitudes
    step(MINV, MINV, 1'b0, "R3");
    step(MINV, MAXV, 1'b0, "R3");
    step(MAXV, MINV, 1'b0, "R3");
    step(MAXV, MAXV, 1'b0, "R3");
    // R8: multiplier patterns that sweep every window code
    step(W'($urandom), 24'hAAAAAA, 1'b0, "R8");
    step(W'($urandom), 24'h555555, 1'b0, "R8");
    step(W'($urandom), 24'h333333, 1'b0, "R8");
    step(W'($urandom), 24'hCCCCCC, 1'b0, "R8");
    step(W'($urandom), 24'h0F0F0F, 1'b0, "R8");
    step(W'($urandom), 24'hF0F0F0, 1'b0, "R8");
    step(MINV, 24'h6DB6DB, 1'b0, "R8");
    // R1 R6 R7: random stream
    for (int i = 0; i < 300; i++) step(W'($urandom), W'($urandom), 1'b0, "R1 R6 R7");
    // R2: reset in the middle of a stream flushes the pipeline
    step(W'($urandom), W'($urandom), 1'b1, "R2");
    step(W'($urandom), W'($urandom), 1'b0, "R2");
    for (int i = 0; i < 20; i++) step(W'($urandom), W'($urandom), 1'b0, "R1");
    // drain the last products
    for (int i = 0; i < 3; i++) step('0, '0, 1'b0, "R4");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule